// File: doc/BRIEF.md
# Three-Axis Motion Event and Interrupt Unit

This block is the event side of a three-axis motion sensor. Signed 8-bit samples come in over a valid/ready stream that carries an axis index. Each sample is limited to a symmetric magnitude and stored. A status byte tracks, for each axis, whether fresh data is waiting and whether a sample was overwritten before it was read.

Two detectors gather over-threshold events per axis. Each detector raises its own active flag under an AND or an OR rule against its enable mask. A click source register can be written directly by the host.

Two interrupt pins each pick one source through a 3-bit code. A single polarity bit sets the active level for both pins. Each source has a latch bit that chooses between a held level and a one-cycle pulse.

The host reaches the configuration and source registers through a register port. The read port is combinational and the write port is single-cycle. Separate read-clear strobes tell the block when the host has consumed an axis value or a source register. The sample stream never applies back-pressure: `smp_ready` is high in every cycle after the first clock edge that follows the release of reset, and a sample is taken in any cycle where `smp_valid` and `smp_ready` are both high.

Top module: `accel_evt_irq`

## Requirements
- R1: A sample is limited to the range -AXIS_LIMIT..+AXIS_LIMIT (default 100) before it is stored. The stored value reads back as two's complement at address 8+n for axis n.
- R2: A sample taken for axis n (0..2) sets status bit n (status is at address 0). If bit n is already set, the sample sets overrun bit 4+n instead.
- R3: Status bit 3 goes high once bits 0..2 are all set. Status bit 7 goes high once bits 4..6 are all set.
- R4: A pulse on `axis_rd` with `axis_rd_sel`=n clears status bits n, 4+n, 3 and 7 at the next edge.
- R5: `ovt_valid` with `ovt_axis`=n sets bit 2n+1 of the low six source bits in both detectors. The detector sources are at addresses 3 and 5; their configurations are at addresses 2 and 4.
- R6: A detector configuration with bit 7 set selects AND mode: source bit 6 is set only when the low six source bits equal configuration bits 5:0. With bit 7 clear (OR mode), any overlap sets bit 6.
- R7: The pin-control register is at address 1. Pin 0 takes its source code from bits 2:0 and pin 1 from bits 5:3. The codes are: 1 detector A, 2 detector B, 3 either detector, 4 data-ready (status bit 3), 7 click (source bit 6 at address 7, configuration at address 6). Codes 0, 5 and 6 keep the pin inactive.
- R8: Pin-control bit 7 set makes both pins active-low. Bit 7 clear makes them active-high.
- R9: If the latch bit (configuration bit 6) of the selected source is clear, the pin is active for exactly one cycle when the condition becomes true. If the latch bit is set, the pin stays active for as long as the condition holds. Data-ready always behaves as latched. For code 3, the latch is the OR of both detectors' latch bits. The pin changes one cycle after the state change that causes it.
- R10: `src_rd` with `src_rd_sel`=0 or 1 clears the whole detector A or B source register. `src_rd_sel`=2 clears only bit 6 of the click source.
- R11: After reset every register reads zero and both pins are low.
- R12: When an axis read-clear and a sample for the same axis arrive in the same cycle, the clear is applied first. The result is data-ready set and overrun clear for that axis.
- R13: `smp_ready` is high in every cycle after the first edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_axis | input | 2 | Axis index of the sample (0..2) |
| smp_data | input | 8 | Signed sample value |
| ovt_valid | input | 1 | Over-threshold event strobe |
| ovt_axis | input | 2 | Axis of the over-threshold event |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| axis_rd | input | 1 | Axis value consumed strobe |
| axis_rd_sel | input | 2 | Axis consumed |
| src_rd | input | 1 | Source register consumed strobe |
| src_rd_sel | input | 2 | 0 detector A, 1 detector B, 2 click |
| irq | output | 2 | Interrupt pins |

## Verification
An axis read-clear and a new sample for the same axis can land in the same cycle, so the clear and the set of the status byte meet. The bench provokes this on an axis whose data-ready and overrun bits are both set, driving both strobes in one cycle. It then expects the status to show data-ready kept and overrun dropped for that axis, with the summary bits cleared. A second overlap puts a source clear and an interrupt re-evaluation in the same cycle: after a detector source read, the pin driven by that detector must fall on the next edge.

// File: rtl/accel_evt_pkg.sv
package accel_evt_pkg;
  localparam int DW      = 8;
  localparam int NAXES   = 3;
  localparam int NPINS   = 2;
  localparam int NDET    = 2;
  localparam int AW      = 4;

  localparam logic [AW-1:0] A_STATUS  = 4'd0;
  localparam logic [AW-1:0] A_PINCTL  = 4'd1;
  localparam logic [AW-1:0] A_DETA_CF = 4'd2;
  localparam logic [AW-1:0] A_DETA_SR = 4'd3;
  localparam logic [AW-1:0] A_DETB_CF = 4'd4;
  localparam logic [AW-1:0] A_DETB_SR = 4'd5;
  localparam logic [AW-1:0] A_CLK_CF  = 4'd6;
  localparam logic [AW-1:0] A_CLK_SR  = 4'd7;
  localparam logic [AW-1:0] A_AXIS0   = 4'd8;

  typedef enum logic [2:0] {
    PSRC_OFF   = 3'd0,
    PSRC_DETA  = 3'd1,
    PSRC_DETB  = 3'd2,
    PSRC_EITH  = 3'd3,
    PSRC_DRDY  = 3'd4,
    PSRC_CLICK = 3'd7
  } pin_src_e;
endpackage

// File: rtl/axis_status.sv
module axis_status
  import accel_evt_pkg::*;
#(
  parameter int LIMIT = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic [1:0]                 take_axis,
  input  logic [DW-1:0]              take_data,
  input  logic                       clr,
  input  logic [1:0]                 clr_axis,
  output logic [DW-1:0]              status,
  output logic [NAXES-1:0][DW-1:0]   axis_vals
);
  localparam logic signed [DW-1:0] POS_LIM = DW'(LIMIT);
  localparam logic signed [DW-1:0] NEG_LIM = -POS_LIM;

  logic [DW-1:0]        st_q, st_d;
  logic signed [DW-1:0] lim_val;

  always_comb begin
    if ($signed(take_data) > POS_LIM)      lim_val = POS_LIM;
    else if ($signed(take_data) < NEG_LIM) lim_val = NEG_LIM;
    else                                   lim_val = $signed(take_data);
  end

  always_comb begin
    st_d = st_q;
    if (clr && (int'(clr_axis) < NAXES)) begin
      st_d[clr_axis]         = 1'b0;
      st_d[{1'b1, clr_axis}] = 1'b0;
      st_d[3]                = 1'b0;
      st_d[7]                = 1'b0;
    end
    if (take && (int'(take_axis) < NAXES)) begin
      if (st_d[take_axis]) st_d[{1'b1, take_axis}] = 1'b1;
      else                 st_d[take_axis]         = 1'b1;
    end
    if (&st_d[2:0]) st_d[3] = 1'b1;
    if (&st_d[6:4]) st_d[7] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  for (genvar g = 0; g < NAXES; g++) begin : g_ax
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   axis_vals[g] <= '0;
      else if (take && (int'(take_axis) == g))      axis_vals[g] <= lim_val;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/motion_detector.sv
module motion_detector
  import accel_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [1:0]    ev_axis,
  input  logic [DW-1:0] cfg,
  input  logic          clr,
  output logic [DW-1:0] src
);
  logic [DW-1:0] src_q, src_d;
  logic [5:0]    low, mask;
  logic          hit;

  always_comb begin
    mask  = 6'b000010 << {ev_axis, 1'b0};
    src_d = clr ? '0 : src_q;
    low   = src_d[5:0] | mask;
    hit   = cfg[7] ? (low == cfg[5:0]) : (|(low & cfg[5:0]));
    if (ev_valid && (int'(ev_axis) < NAXES))
      src_d = {1'b0, src_d[6] | hit, low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src = src_q;
endmodule

// File: rtl/irq_pin.sv
module irq_pin
  import accel_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic          active_low,
  input  logic [DW-1:0] deta_src,
  input  logic [DW-1:0] deta_cfg,
  input  logic [DW-1:0] detb_src,
  input  logic [DW-1:0] detb_cfg,
  input  logic          drdy,
  input  logic [DW-1:0] click_src,
  input  logic [DW-1:0] click_cfg,
  output logic          pin
);
  logic cond, latch, cond_q, act, pin_q;

  always_comb begin
    cond  = 1'b0;
    latch = 1'b0;
    case (pin_src_e'(sel))
      PSRC_DETA:  begin cond = deta_src[6]; latch = deta_cfg[6]; end
      PSRC_DETB:  begin cond = detb_src[6]; latch = detb_cfg[6]; end
      PSRC_EITH:  begin
        cond  = deta_src[6] | detb_src[6];
        latch = deta_cfg[6] | detb_cfg[6];
      end
      PSRC_DRDY:  begin cond = drdy; latch = 1'b1; end
      PSRC_CLICK: begin cond = click_src[6]; latch = click_cfg[6]; end
      default:    begin cond = 1'b0; latch = 1'b0; end
    endcase
    act = cond & (latch | ~cond_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      pin_q  <= act ^ active_low;
    end
  end

  assign pin = pin_q;
endmodule

// File: rtl/accel_evt_irq.sv
module accel_evt_irq
  import accel_evt_pkg::*;
#(
  parameter int AXIS_LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [1:0]    smp_axis,
  input  logic [7:0]    smp_data,
  input  logic          ovt_valid,
  input  logic [1:0]    ovt_axis,
  input  logic          reg_wen,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          axis_rd,
  input  logic [1:0]    axis_rd_sel,
  input  logic          src_rd,
  input  logic [1:0]    src_rd_sel,
  output logic [1:0]    irq
);
  logic                     ready_q;
  logic                     take;
  logic [DW-1:0]            status;
  logic [NAXES-1:0][DW-1:0] axis_vals;
  logic [DW-1:0]            pin_ctl;
  logic [NDET-1:0][DW-1:0]  det_cfg;
  logic [NDET-1:0][DW-1:0]  det_src;
  logic [DW-1:0]            click_cfg, click_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign smp_ready = ready_q;
  assign take      = smp_valid & ready_q;

  axis_status #(.LIMIT(AXIS_LIMIT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .take_axis (smp_axis),
    .take_data (smp_data),
    .clr       (axis_rd),
    .clr_axis  (axis_rd_sel),
    .status    (status),
    .axis_vals (axis_vals)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_ctl   <= '0;
      click_cfg <= '0;
    end else if (reg_wen) begin
      if (reg_addr == A_PINCTL) pin_ctl   <= reg_wdata;
      if (reg_addr == A_CLK_CF) click_cfg <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  click_src <= '0;
    else if (reg_wen && reg_addr == A_CLK_SR)    click_src <= reg_wdata;
    else if (src_rd && src_rd_sel == 2'd2)       click_src[6] <= 1'b0;
  end

  for (genvar d = 0; d < NDET; d++) begin : g_det
    localparam logic [AW-1:0] CF_ADDR = AW'(A_DETA_CF + 2 * d);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               det_cfg[d] <= '0;
      else if (reg_wen && reg_addr == CF_ADDR)  det_cfg[d] <= reg_wdata;
    end
    motion_detector u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ovt_valid),
      .ev_axis  (ovt_axis),
      .cfg      (det_cfg[d]),
      .clr      (src_rd && (int'(src_rd_sel) == d)),
      .src      (det_src[d])
    );
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    irq_pin u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (pin_ctl[3*p +: 3]),
      .active_low (pin_ctl[7]),
      .deta_src   (det_src[0]),
      .deta_cfg   (det_cfg[0]),
      .detb_src   (det_src[1]),
      .detb_cfg   (det_cfg[1]),
      .drdy       (status[3]),
      .click_src  (click_src),
      .click_cfg  (click_cfg),
      .pin        (irq[p])
    );
  end

  always_comb begin
    case (reg_addr)
      A_STATUS:  reg_rdata = status;
      A_PINCTL:  reg_rdata = pin_ctl;
      A_DETA_CF: reg_rdata = det_cfg[0];
      A_DETA_SR: reg_rdata = det_src[0];
      A_DETB_CF: reg_rdata = det_cfg[1];
      A_DETB_SR: reg_rdata = det_src[1];
      A_CLK_CF:  reg_rdata = click_cfg;
      A_CLK_SR:  reg_rdata = click_src;
      4'd8:      reg_rdata = axis_vals[0];
      4'd9:      reg_rdata = axis_vals[1];
      4'd10:     reg_rdata = axis_vals[2];
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/accel_evt_irq_chk.sv
module accel_evt_irq_chk #(
  parameter int LIMIT = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [1:0]       smp_axis,
  input logic             axis_rd,
  input logic [1:0]       axis_rd_sel,
  input logic             src_rd,
  input logic [1:0]       src_rd_sel,
  input logic             ovt_valid,
  input logic [7:0]       status,
  input logic [7:0]       pin_ctl,
  input logic [7:0]       deta_src,
  input logic [2:0][7:0]  axis_vals,
  input logic [1:0]       irq
);
  logic take;
  assign take = smp_valid & smp_ready;

  assert_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> smp_ready);

  assert_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && smp_axis != 2'd3) |=>
      ($signed(axis_vals[$past(smp_axis)]) <= LIMIT &&
       $signed(axis_vals[$past(smp_axis)]) >= -LIMIT));

  assert_overrun_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && smp_axis != 2'd3 && status[smp_axis] && !axis_rd) |=>
      status[{1'b1, $past(smp_axis)}]);

  assert_rdclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (axis_rd && axis_rd_sel != 2'd3 && !take) |=>
      (!status[$past(axis_rd_sel)] && !status[{1'b1, $past(axis_rd_sel)}] &&
       !status[3] && !status[7]));

  assert_srcclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && src_rd_sel == 2'd0 && !ovt_valid) |=> (deta_src == 8'd0));

  assert_idle_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ctl[2:0] == 3'd0 || pin_ctl[2:0] == 3'd5 || pin_ctl[2:0] == 3'd6) |=>
      (irq[0] == $past(pin_ctl[7])));
endmodule

bind accel_evt_irq accel_evt_irq_chk #(.LIMIT(AXIS_LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_axis    (smp_axis),
  .axis_rd     (axis_rd),
  .axis_rd_sel (axis_rd_sel),
  .src_rd      (src_rd),
  .src_rd_sel  (src_rd_sel),
  .ovt_valid   (ovt_valid),
  .status      (status),
  .pin_ctl     (pin_ctl),
  .deta_src    (det_src[0]),
  .axis_vals   (axis_vals),
  .irq         (irq)
);

// File: tb/accel_evt_irq_tb.sv
module accel_evt_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [1:0] smp_axis = '0;
  logic [7:0] smp_data = '0;
  logic       ovt_valid = 1'b0;
  logic [1:0] ovt_axis = '0;
  logic       reg_wen = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       axis_rd = 1'b0;
  logic [1:0] axis_rd_sel = '0;
  logic       src_rd = 1'b0;
  logic [1:0] src_rd_sel = '0;
  logic [1:0] irq;

  always #5 clk = ~clk;

  accel_evt_irq u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_axis(smp_axis), .smp_data(smp_data), .ovt_valid(ovt_valid),
    .ovt_axis(ovt_axis), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .axis_rd(axis_rd),
    .axis_rd_sel(axis_rd_sel), .src_rd(src_rd), .src_rd_sel(src_rd_sel),
    .irq(irq)
  );

  typedef struct {
    int         kind;   // 0 register, 1 irq pair, 2 ready
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int pending = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {6'd0, irq};
        default: act = {7'd0, smp_ready};
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
      pending--;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic exp_reg(logic [3:0] a, logic [7:0] e, string tag);
    reg_addr = a;
    push(0, e, tag);
  endtask

  task automatic exp_irq(logic [1:0] e, string tag);
    push(1, {6'd0, e}, tag);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wen = 1'b0;
  endtask

  task automatic sample(logic [1:0] ax, logic [7:0] d);
    smp_valid = 1'b1; smp_axis = ax; smp_data = d;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic ovt(logic [1:0] ax);
    ovt_valid = 1'b1; ovt_axis = ax;
    tick();
    ovt_valid = 1'b0;
  endtask

  task automatic axrd(logic [1:0] ax);
    axis_rd = 1'b1; axis_rd_sel = ax;
    tick();
    axis_rd = 1'b0;
  endtask

  task automatic srcrd(logic [1:0] s);
    src_rd = 1'b1; src_rd_sel = s;
    tick();
    src_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    exp_reg(4'd0, 8'h00, "R11 status");
    exp_reg(4'd3, 8'h00, "R11 detA src");
    exp_irq(2'b00, "R11 pins");
    // R13 ready after reset
    push(2, 8'h01, "R13 ready");

    // R1 limiting
    sample(2'd0, 8'd120);
    exp_reg(4'd8, 8'h64, "R1 x clamp high");
    sample(2'd1, 8'h80);
    exp_reg(4'd9, 8'h9C, "R1 y clamp low");
    sample(2'd2, 8'd50);
    exp_reg(4'd10, 8'd50, "R1 z pass");
    // R3 data-ready summary
    exp_reg(4'd0, 8'h0F, "R3 all ready");
    // R2 overrun
    sample(2'd0, 8'd1);
    exp_reg(4'd0, 8'h1F, "R2 x overrun");
    sample(2'd1, 8'd2);
    sample(2'd2, 8'd3);
    exp_reg(4'd0, 8'hFF, "R3 all overrun");
    // R4 axis read-clear
    axrd(2'd0);
    exp_reg(4'd0, 8'h66, "R4 clear x");
    // R12 same-cycle clear and sample
    axis_rd = 1'b1; axis_rd_sel = 2'd1;
    smp_valid = 1'b1; smp_axis = 2'd1; smp_data = 8'd7;
    tick();
    axis_rd = 1'b0; smp_valid = 1'b0;
    exp_reg(4'd0, 8'h46, "R12 clear then set");

    // R5 / R6 detectors
    wr(4'd2, 8'h02);
    wr(4'd4, 8'h8A);
    ovt(2'd0);
    exp_reg(4'd3, 8'h42, "R6 OR hit");
    exp_reg(4'd5, 8'h02, "R6 AND partial");
    ovt(2'd1);
    exp_reg(4'd3, 8'h4A, "R5 y bit");
    exp_reg(4'd5, 8'h4A, "R6 AND full");
    // R10 detector clear
    srcrd(2'd0);
    exp_reg(4'd3, 8'h00, "R10 detA cleared");
    exp_reg(4'd5, 8'h4A, "R10 detB kept");

    // R9 pulse: pin0 <- detector B, latch clear
    wr(4'd1, 8'h02);
    exp_irq(2'b00, "R9 not yet");
    tick();
    exp_irq(2'b01, "R9 pulse high");
    tick();
    exp_irq(2'b00, "R9 pulse ends");
    // R9 latched
    wr(4'd4, 8'hCA);
    tick();
    exp_irq(2'b01, "R9 latched");
    tick();
    exp_irq(2'b01, "R9 held");
    srcrd(2'd1);
    tick();
    exp_irq(2'b00, "R10 detB read drops pin");
    // R8 polarity
    wr(4'd1, 8'h82);
    tick();
    exp_irq(2'b11, "R8 active low idle");

    // R7 data-ready on pin1
    wr(4'd1, 8'h20);
    tick();
    exp_irq(2'b00, "R7 drdy idle");
    sample(2'd0, 8'd9);
    exp_reg(4'd0, 8'h4F, "R3 ready again");
    tick();
    exp_irq(2'b10, "R7 drdy level");
    axrd(2'd0);
    tick();
    exp_irq(2'b00, "R7 drdy cleared");

    // R7 either-detector and inactive code
    wr(4'd2, 8'h42);
    wr(4'd1, 8'h03);
    ovt(2'd0);
    tick();
    exp_irq(2'b01, "R7 either detector");
    wr(4'd1, 8'h05);
    tick();
    exp_irq(2'b00, "R7 code 5 inactive");

    // R7 click source on pin1, R10 click clear
    wr(4'd6, 8'h40);
    wr(4'd7, 8'h41);
    wr(4'd1, 8'h38);
    tick();
    exp_irq(2'b10, "R7 click");
    srcrd(2'd2);
    exp_reg(4'd7, 8'h01, "R10 click bit6 only");
    tick();
    exp_irq(2'b00, "R10 click pin drops");

    // R5 z axis event into both detectors
    ovt(2'd2);
    exp_reg(4'd3, 8'h62, "R5 z detA");
    exp_reg(4'd5, 8'h22, "R5 z detB");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule